// File: doc/BRIEF.md
# Silence-Triggered Output Damping Controller

This block sits between a stereo sample receiver and the PWM output stage. It watches each accepted left/right sample pair and decides when the output bridges must be put into the damped state. In that state the load is shorted to ground. The block enters the damped state in two ways. The first is a long unbroken run of silent sample pairs. The second is an active-high forced-mute pin.

Silence is judged only on the significant part of each sample word. Samples arrive MSB-justified in a word of up to 24 bits, and only the upper 16 bits are used. A run counter advances on every valid pair in which both channels are silent. Once the count reaches the threshold, the block mutes itself. The first valid pair carrying a non-silent word on either channel releases the auto-mute at once.

The modulator's two drive bits per channel pass through the block. While the block is damped they are replaced by the grounded level.

Top module: `silence_damp_ctrl`

## Requirements
- R1: The damped flag rises at the clock edge that accepts the ZERO_RUN-th (default 2048) consecutive valid pair in which both words are silent. It is still low after the (ZERO_RUN-1)-th such pair.
- R2: A valid pair with a non-silent word on either channel clears the auto-mute at the edge that accepts it. If the mute pin is low, the damped flag falls at that same edge.
- R3: A valid pair with a non-silent word on either channel restarts the silence run, so a further full ZERO_RUN silent pairs are needed to mute.
- R4: While the mute pin is high, the damped flag is high after every clock edge that samples the pin, whatever the sample data.
- R5: While damped, both drive bits of each channel (bit 0 = bridge side A, bit 1 = side B) are 0, which grounds both sides. While not damped, each output pair equals its input pair.
- R6: The run count saturates at ZERO_RUN. Silence of any length beyond the threshold keeps the block muted, and the first non-silent word still releases it.
- R7: Only bits [WORD_W-1:WORD_W-USED_W] (default [23:8]) decide silence. A word that is non-zero only in the low WORD_W-USED_W bits counts as silent.
- R8: When the valid strobe is low, the damped flag changes only if the mute pin changes. Such cycles neither advance nor break the silence run, whatever data is present.
- R9: After reset the damped flag is low, the run count is zero and the drive outputs follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Strobe marking an accepted left/right sample pair |
| leftWord | input | WORD_W | Left sample, MSB-justified |
| rightWord | input | WORD_W | Right sample, MSB-justified |
| muteIn | input | 1 | Forced mute, active high |
| pwmLIn | input | 2 | Left drive pair from modulator (bit0 side A, bit1 side B) |
| pwmRIn | input | 2 | Right drive pair from modulator |
| damped | output | 1 | Registered damped-state flag |
| pwmLOut | output | 2 | Left drive pair to bridge, grounded while damped |
| pwmROut | output | 2 | Right drive pair to bridge, grounded while damped |

## Verification
The damped flag is a single register. It reflects a sample pair or a mute-pin level one clock edge after the inputs are presented. The drive outputs are a combinational function of that flag and the input pairs, so they are due in the same cycle as the flag. The bench drives inputs at the falling edge and steps its reference model at the rising edge. It then compares the flag and both drive pairs a quarter period later. Every vector is compared, and this includes the idle-strobe cycles that must leave the flag untouched.

// File: rtl/silence_damp_pkg.sv
package silence_damp_pkg;

  // Strobes issued by the control to the run-length datapath.
  typedef struct packed {
    logic runAdvance;  // valid pair, both channels silent
    logic runRestart;  // valid pair, some channel audible
  } runStrobe_t;

  localparam int unsigned NUM_CHAN = 2;

endpackage

// File: rtl/silence_run_path.sv
module silence_run_path
  import silence_damp_pkg::*;
#(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned USED_W   = 16,
  parameter int unsigned ZERO_RUN = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] leftWord,
  input  logic [WORD_W-1:0] rightWord,
  input  runStrobe_t        strobe,
  output logic              pairSilent,
  output logic              runDue
);

  localparam int unsigned CNT_W = $clog2(ZERO_RUN + 1);
  localparam int unsigned LSB   = WORD_W - USED_W;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ZERO_RUN);
  localparam logic [CNT_W-1:0] CNT_DUE = CNT_W'(ZERO_RUN - 1);

  logic [WORD_W-1:0]   chanWord   [NUM_CHAN];
  logic [NUM_CHAN-1:0] chanSilent;
  logic [CNT_W-1:0]    runCnt;

  assign chanWord[0] = leftWord;
  assign chanWord[1] = rightWord;

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    assign chanSilent[ch] = (chanWord[ch][WORD_W-1:LSB] == '0);
  end

  assign pairSilent = &chanSilent;
  assign runDue     = (runCnt >= CNT_DUE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobe.runRestart) begin
      runCnt <= '0;
    end else if (strobe.runAdvance && (runCnt != CNT_MAX)) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R6: the run count never passes its threshold
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= CNT_MAX);

  // R6: a saturated count stays put under continued silence
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (runCnt == CNT_MAX) && strobe.runAdvance |=> runCnt == CNT_MAX);

  // R3: an audible pair restarts the run
  p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.runRestart |=> runCnt == '0);

  // R8: without a strobe the count is left alone
  p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.runAdvance && !strobe.runRestart |=> $stable(runCnt));

  // strobes are exclusive
  p_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.runAdvance, strobe.runRestart}));

endmodule

// File: rtl/damp_ctrl.sv
module damp_ctrl
  import silence_damp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic       muteIn,
  input  logic       pairSilent,
  input  logic       runDue,
  input  logic [1:0] pwmLIn,
  input  logic [1:0] pwmRIn,
  output runStrobe_t strobe,
  output logic       damped,
  output logic [1:0] pwmLOut,
  output logic [1:0] pwmROut
);

  logic autoMute;
  logic autoNext;
  logic dampedQ;

  always_comb begin
    strobe.runAdvance = sampleValid && pairSilent;
    strobe.runRestart = sampleValid && !pairSilent;
    if (sampleValid) autoNext = pairSilent && runDue;
    else             autoNext = autoMute;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoMute <= 1'b0;
      dampedQ  <= 1'b0;
    end else begin
      autoMute <= autoNext;
      dampedQ  <= autoNext || muteIn;
    end
  end

  assign damped  = dampedQ;
  assign pwmLOut = dampedQ ? 2'b00 : pwmLIn;
  assign pwmROut = dampedQ ? 2'b00 : pwmRIn;

  // R4: forced mute pin always wins
  p_pin_forces_r4: assert property (@(posedge clk) disable iff (!rstN)
    muteIn |=> damped);

  // R2: an audible pair releases when the pin is low
  p_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !pairSilent && !muteIn |=> !damped);

  // R1: the last pair of a full silent run engages the mute
  p_engage_r1: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && pairSilent && runDue |=> damped);

  // R8: no strobe and a steady pin leave the flag unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid && $stable(muteIn) && !muteIn |=> $stable(damped));

  // R5: both bridge sides grounded while damped
  p_ground_r5: assert property (@(posedge clk) disable iff (!rstN)
    damped |-> (pwmLOut == 2'b00) && (pwmROut == 2'b00));

endmodule

// File: rtl/silence_damp_ctrl.sv
module silence_damp_ctrl
  import silence_damp_pkg::*;
#(
  parameter int unsigned WORD_W   = 24,
  parameter int unsigned USED_W   = 16,
  parameter int unsigned ZERO_RUN = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] leftWord,
  input  logic [WORD_W-1:0] rightWord,
  input  logic              muteIn,
  input  logic [1:0]        pwmLIn,
  input  logic [1:0]        pwmRIn,
  output logic              damped,
  output logic [1:0]        pwmLOut,
  output logic [1:0]        pwmROut
);

  runStrobe_t strobe;
  logic       pairSilent;
  logic       runDue;

  silence_run_path #(
    .WORD_W  (WORD_W),
    .USED_W  (USED_W),
    .ZERO_RUN(ZERO_RUN)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .leftWord  (leftWord),
    .rightWord (rightWord),
    .strobe    (strobe),
    .pairSilent(pairSilent),
    .runDue    (runDue)
  );

  damp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .muteIn     (muteIn),
    .pairSilent (pairSilent),
    .runDue     (runDue),
    .pwmLIn     (pwmLIn),
    .pwmRIn     (pwmRIn),
    .strobe     (strobe),
    .damped     (damped),
    .pwmLOut    (pwmLOut),
    .pwmROut    (pwmROut)
  );

endmodule

// File: tb/tb_silence_damp_ctrl.sv
module tb_silence_damp_ctrl;

  localparam int unsigned WORD_W   = 24;
  localparam int unsigned USED_W   = 16;
  localparam int unsigned ZERO_RUN = 2048;
  localparam int unsigned LSB      = WORD_W - USED_W;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic [WORD_W-1:0] leftWord = '0;
  logic [WORD_W-1:0] rightWord = '0;
  logic              muteIn = 1'b0;
  logic [1:0]        pwmLIn = 2'b00;
  logic [1:0]        pwmRIn = 2'b00;
  logic              damped;
  logic [1:0]        pwmLOut;
  logic [1:0]        pwmROut;

  int unsigned vecCount  = 0;
  int unsigned failCount = 0;
  int unsigned expRun    = 0;
  bit          expAuto   = 1'b0;
  bit          expDamped = 1'b0;
  bit          finished  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  silence_damp_ctrl #(
    .WORD_W(WORD_W), .USED_W(USED_W), .ZERO_RUN(ZERO_RUN)
  ) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .leftWord(leftWord), .rightWord(rightWord), .muteIn(muteIn),
    .pwmLIn(pwmLIn), .pwmRIn(pwmRIn),
    .damped(damped), .pwmLOut(pwmLOut), .pwmROut(pwmROut)
  );

  function automatic bit isSilent(logic [WORD_W-1:0] w);
    return w[WORD_W-1:LSB] == '0;
  endfunction

  function automatic logic [1:0] expDrive(bit d, logic [1:0] inPair);
    return d ? 2'b00 : inPair;
  endfunction

  task automatic compare(string req);
    vecCount++;
    if (damped !== expDamped) begin
      failCount++;
      $display("FAIL %s damped act=%0b exp=%0b t=%0t", req, damped, expDamped, $time);
    end
    if (pwmLOut !== expDrive(expDamped, pwmLIn) ||
        pwmROut !== expDrive(expDamped, pwmRIn)) begin
      failCount++;
      $display("FAIL %s drive act=%b/%b exp=%b/%b t=%0t", req, pwmLOut, pwmROut,
               expDrive(expDamped, pwmLIn), expDrive(expDamped, pwmRIn), $time);
    end
  endtask

  // drive at falling edge, step model at rising edge, check a quarter period later
  task automatic step(bit v, logic [WORD_W-1:0] l, logic [WORD_W-1:0] r,
                      bit m, string req);
    @(negedge clk);
    sampleValid = v; leftWord = l; rightWord = r; muteIn = m;
    pwmLIn = 2'($urandom); pwmRIn = 2'($urandom);
    @(posedge clk);
    if (v) begin
      if (isSilent(l) && isSilent(r)) begin
        if (expRun < ZERO_RUN) expRun++;
        expAuto = (expRun >= ZERO_RUN);
      end else begin
        expRun = 0;
        expAuto = 1'b0;
      end
    end
    expDamped = expAuto || m;
    #(CLK_PERIOD/4);
    compare(req);
  endtask

  function automatic logic [WORD_W-1:0] lowJunk();
    return WORD_W'($urandom_range(255, 0));
  endfunction

  task automatic silentRun(int unsigned n, string req);
    for (int i = 0; i < n; i++) step(1'b1, lowJunk(), lowJunk(), 1'b0, req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    compare("R9 reset");
    @(negedge clk) rstN = 1'b1;
    step(1'b0, '0, '0, 1'b0, "R9 after reset");

    // R1 threshold, R7 low bits ignored
    silentRun(ZERO_RUN - 1, "R7 low bits silent");
    if (damped !== 1'b0) begin
      failCount++; $display("FAIL R1 early act=%0b exp=0", damped);
    end
    vecCount++;
    step(1'b1, '0, '0, 1'b0, "R1 engage");
    // R6 saturation and release
    silentRun(ZERO_RUN + 300, "R6 saturate");
    step(1'b0, 24'hFFFF00, 24'h123400, 1'b0, "R8 idle audible data");
    step(1'b1, '0, 24'h000100, 1'b0, "R2 release right");
    // R3 restart from either channel
    silentRun(ZERO_RUN - 1, "R3 run");
    step(1'b1, 24'h800000, '0, 1'b0, "R3 left breaks");
    silentRun(ZERO_RUN - 1, "R3 second run");
    step(1'b0, '0, '0, 1'b0, "R8 idle no advance");
    step(1'b1, '0, '0, 1'b0, "R3 engage after restart");
    step(1'b1, 24'h000100, '0, 1'b0, "R2 release left");
    // R4 forced mute
    step(1'b1, 24'h7FFF00, 24'h7FFF00, 1'b1, "R4 pin forces");
    step(1'b0, 24'h7FFF00, 24'h7FFF00, 1'b1, "R4 pin held");
    step(1'b0, '0, '0, 1'b0, "R4 pin drop");
    step(1'b0, '0, '0, 1'b0, "R8 hold low");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      logic [WORD_W-1:0] l, r;
      sel = $urandom_range(99, 0);
      l = (sel < 70) ? lowJunk() : WORD_W'($urandom);
      r = (sel < 85) ? lowJunk() : WORD_W'($urandom);
      step(($urandom_range(3, 0) != 0), l, r, ($urandom_range(19, 0) == 0),
           "R8 random mix");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

endmodule